// File: doc/BRIEF.md
# MDIO Command Controller

This block is a management-interface master for Ethernet PHYs. Software talks to it through one 32-bit command/status word on a simple write-strobe bus. The word is always visible on the read-data output. One bus write carries the PHY address, the register address, a direction bit and, for a write, the 16-bit payload. The block then serialises a Clause-22 management frame on MDC/MDIO and holds off any further command until that frame is over.

When the frame ends, bit 15 of the word is set. For a read, the 16 bits returned by the PHY replace the upper half of the word. Software polls the word, takes the result and clears the flag by writing a one to it before it issues the next command. A frame takes 128 × HALF_CYCLES system clocks, which is far below any practical polling timeout. MDC is derived from the system clock with a divider whose half period is HALF_CYCLES clocks. The block releases MDIO through an output enable while the PHY drives the bus.

Top module: `mdio_cmd_ctrl`

## Requirements
- R1: After reset the command word reads 0, MDC is low, and MDIO is undriven (enable low, data low).
- R2: A write while idle starts a frame only when exactly one of bit 13 (write) and bit 14 (read) is set. A write with both bits set, or with neither, starts no frame and leaves bits 31:16 and 14:0 unchanged.
- R3: MDC stays low when idle. From the accept edge it spends HALF_CYCLES clocks low, then HALF_CYCLES clocks high, and repeats this for 64 periods.
- R4: The frame is sent MSB first, one bit per MDC period, in this order:
  - 32 ones;
  - start 01;
  - opcode 01 for a write or 10 for a read;
  - PHY address from bits 4:0;
  - register address from bits 12:8;
  - for a write, turnaround 10 and then bits 31:16.
  MDIO changes only with a falling MDC edge or on the accept edge.
- R5: For a read, the output enable drops at the first turnaround bit (frame bit 46) and stays low to the end of the frame, with mdio_o held low. The 16 data bits are sampled on the MDC rising edges of frame bits 48 to 63, MSB first.
- R6: The frame ends 128 × HALF_CYCLES clocks after the accept edge, with MDC low and the enable low. One clock later:
  - bit 15 reads 1;
  - bits 14:13 read 0;
  - bits 31:16 hold the read data after a read, or keep the write data after a write.
- R7: While idle, a write with bit 15 set clears the flag. A write with bit 15 clear and no command leaves the flag unchanged.
- R8: Every write while a command is in progress is ignored, including one on the clock edge where the flag is set. Ignored means no new frame, no change to the word, and no effect on the current frame.
- R9: Accepting a new command clears the flag even when software did not clear it first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Write strobe for the command word |
| reg_wdata_i | input | 32 | Write data for the command word |
| reg_rdata_o | output | 32 | Current command/status word |
| mdc_o | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | Management data out |
| mdio_oe_o | output | 1 | Output enable for MDIO |
| mdio_i | input | 1 | Management data in |

## Verification
Two events can fall on the same edge: the completion of a frame, which sets the flag and loads the read data, and a new bus write of a command or a flag clear. The bench waits until its reference model shows the cycle just before the flag rises. It then places a valid read command on the bus so that the write strobe and the completion share one edge. It judges the result every clock afterwards: no second frame may start on MDC/MDIO, and the word must show the flag set, cleared command bits and the data of the earlier read. Writes in the middle of a frame are checked the same way, against an unchanged serial stream.

// File: rtl/mdio_cmd_pkg.sv
package mdio_cmd_pkg;
  localparam int FRAME_BITS = 64;
  localparam int PRE_BITS   = 32;
  localparam int TA_BIT     = 46;  // first turnaround bit
  localparam int DATA_BIT   = 48;  // first data bit
  localparam int BIT_W      = $clog2(FRAME_BITS);

  // command word field positions
  localparam int F_WR   = 13;
  localparam int F_RD   = 14;
  localparam int F_DONE = 15;

  typedef struct packed {
    logic [4:0]  phy;
    logic [4:0]  regad;
    logic        is_read;
    logic [15:0] wdata;
  } mdio_cmd_t;

  function automatic logic [FRAME_BITS-1:0] build_frame(mdio_cmd_t c);
    logic [1:0] op, ta;
    op = c.is_read ? 2'b10 : 2'b01;
    ta = c.is_read ? 2'b00 : 2'b10;
    return {{PRE_BITS{1'b1}}, 2'b01, op, c.phy, c.regad, ta,
            (c.is_read ? 16'h0 : c.wdata)};
  endfunction
endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
  parameter int HALF_CYCLES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic mdc_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int CW = (HALF_CYCLES > 1) ? $clog2(HALF_CYCLES) : 1;

  logic [CW-1:0] cnt_q;
  logic          mdc_q;
  logic          wrap;

  assign wrap = (cnt_q == CW'(HALF_CYCLES - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (!en_i) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (wrap) begin
      cnt_q <= '0;
      mdc_q <= ~mdc_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign mdc_o  = mdc_q;
  assign rise_o = en_i & wrap & ~mdc_q;
  assign fall_o = en_i & wrap & mdc_q;

  // R3
  mdc_idle_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !mdc_o);
endmodule

// File: rtl/mdio_frame_eng.sv
module mdio_frame_eng
  import mdio_cmd_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  mdio_cmd_t   cmd_i,
  input  logic        rise_i,
  input  logic        fall_i,
  input  logic        mdio_i,
  output logic        busy_o,
  output logic        done_o,
  output logic [15:0] rdata_o,
  output logic        mdio_o,
  output logic        mdio_oe_o
);
  logic                  busy_q, is_rd_q, oe_q, done_q;
  logic [FRAME_BITS-1:0] shift_q;
  logic [BIT_W-1:0]      bit_q;
  logic [15:0]           rd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      is_rd_q <= 1'b0;
      oe_q    <= 1'b0;
      done_q  <= 1'b0;
      shift_q <= '0;
      bit_q   <= '0;
      rd_q    <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_i && !busy_q) begin
        busy_q  <= 1'b1;
        is_rd_q <= cmd_i.is_read;
        oe_q    <= 1'b1;
        shift_q <= build_frame(cmd_i);
        bit_q   <= '0;
        rd_q    <= '0;
      end else if (busy_q) begin
        if (rise_i && is_rd_q && bit_q >= BIT_W'(DATA_BIT))
          rd_q <= {rd_q[14:0], mdio_i};
        if (fall_i) begin
          if (bit_q == BIT_W'(FRAME_BITS - 1)) begin
            busy_q <= 1'b0;
            oe_q   <= 1'b0;
            done_q <= 1'b1;
          end else begin
            bit_q   <= bit_q + 1'b1;
            shift_q <= shift_q << 1;
            if (is_rd_q && bit_q == BIT_W'(TA_BIT - 1)) oe_q <= 1'b0;
          end
        end
      end
    end
  end

  assign busy_o    = busy_q;
  assign done_o    = done_q;
  assign rdata_o   = rd_q;
  assign mdio_o    = oe_q & shift_q[FRAME_BITS-1];
  assign mdio_oe_o = oe_q;

  // R5
  read_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && is_rd_q && bit_q >= BIT_W'(TA_BIT)) |-> !mdio_oe_o);

  // R4
  mdio_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && $past(busy_q) && !$past(fall_i)) |-> $stable(mdio_o));
endmodule

// File: rtl/mdio_cmd_ctrl.sv
module mdio_cmd_ctrl
  import mdio_cmd_pkg::*;
#(
  parameter int HALF_CYCLES = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_we_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  output logic        mdc_o,
  output logic        mdio_o,
  output logic        mdio_oe_o,
  input  logic        mdio_i
);
  logic [4:0]  phy_q, regad_q;
  logic        cmd_wr_q, cmd_rd_q, flag_q, busy_q;
  logic [15:0] data_q;
  logic        accept;
  logic        eng_busy, eng_done, rise, fall;
  logic [15:0] eng_rdata;
  mdio_cmd_t   cmd;

  assign accept = reg_we_i && !busy_q && (reg_wdata_i[F_WR] ^ reg_wdata_i[F_RD]);

  assign cmd.phy     = reg_wdata_i[4:0];
  assign cmd.regad   = reg_wdata_i[12:8];
  assign cmd.is_read = reg_wdata_i[F_RD];
  assign cmd.wdata   = reg_wdata_i[31:16];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phy_q    <= '0;
      regad_q  <= '0;
      cmd_wr_q <= 1'b0;
      cmd_rd_q <= 1'b0;
      flag_q   <= 1'b0;
      busy_q   <= 1'b0;
      data_q   <= '0;
    end else if (accept) begin
      phy_q    <= cmd.phy;
      regad_q  <= cmd.regad;
      cmd_wr_q <= ~cmd.is_read;
      cmd_rd_q <= cmd.is_read;
      data_q   <= cmd.wdata;
      flag_q   <= 1'b0;
      busy_q   <= 1'b1;
    end else if (busy_q) begin
      if (eng_done) begin
        busy_q   <= 1'b0;
        cmd_wr_q <= 1'b0;
        cmd_rd_q <= 1'b0;
        flag_q   <= 1'b1;
        if (cmd_rd_q) data_q <= eng_rdata;
      end
    end else if (reg_we_i && reg_wdata_i[F_DONE]) begin
      flag_q <= 1'b0;
    end
  end

  assign reg_rdata_o = {data_q, flag_q, cmd_rd_q, cmd_wr_q, regad_q, 3'b000, phy_q};

  mdio_clk_div #(.HALF_CYCLES(HALF_CYCLES)) div_i (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (eng_busy),
    .mdc_o (mdc_o),
    .rise_o(rise),
    .fall_o(fall)
  );

  mdio_frame_eng eng_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (accept),
    .cmd_i    (cmd),
    .rise_i   (rise),
    .fall_i   (fall),
    .mdio_i   (mdio_i),
    .busy_o   (eng_busy),
    .done_o   (eng_done),
    .rdata_o  (eng_rdata),
    .mdio_o   (mdio_o),
    .mdio_oe_o(mdio_oe_o)
  );

  // R8
  busy_fields_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |=> $stable({phy_q, regad_q}));

  // R6
  done_sets_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_done |=> flag_q);

  // R2
  one_cmd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({cmd_rd_q, cmd_wr_q}));

  // R9
  accept_clears_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> !flag_q);
endmodule

// File: tb/mdio_cmd_ctrl_tb_top.sv
`timescale 1ns/1ps
module mdio_cmd_ctrl_tb_top;
  localparam int HALF = 2;
  localparam int TOT  = 128 * HALF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        mdc, mdio_out, mdio_oe;
  logic        mdio_in = 1'b1;

  int checks = 0;
  int fails  = 0;
  string tag = "R1";

  // reference model state
  bit          m_busy = 0;
  int          k = 0;
  logic [4:0]  m_phy = '0, m_reg = '0;
  bit          m_wr = 0, m_rd = 0, m_flag = 0;
  logic [15:0] m_data = '0;
  logic [15:0] m_rdval = '0;
  logic [63:0] fvec = '0;

  always #2.5 clk = ~clk;

  mdio_cmd_ctrl #(.HALF_CYCLES(HALF)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .mdc_o(mdc), .mdio_o(mdio_out), .mdio_oe_o(mdio_oe),
    .mdio_i(mdio_in)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; k = 0; m_phy = '0; m_reg = '0;
      m_wr = 0; m_rd = 0; m_flag = 0; m_data = '0;
    end else if (m_busy) begin
      k++;
      if (k == TOT + 1) begin
        m_busy = 0; m_flag = 1; m_wr = 0;
        if (m_rd) m_data = m_rdval;
        m_rd = 0;
      end
    end else if (we) begin
      if (wdata[15]) m_flag = 0;
      if (wdata[13] ^ wdata[14]) begin
        m_phy = wdata[4:0]; m_reg = wdata[12:8];
        m_wr = wdata[13]; m_rd = wdata[14];
        m_data = wdata[31:16]; m_flag = 0; m_busy = 1; k = 0;
        fvec = {32'hFFFF_FFFF, 2'b01, (m_rd ? 2'b10 : 2'b01), m_phy, m_reg,
                (m_rd ? 2'b00 : 2'b10), (m_rd ? 16'h0 : m_data)};
      end
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      bit e_mdc, e_oe, e_mdio;
      int b;
      b = k / (2 * HALF);
      if (m_busy && k < TOT) begin
        e_mdc  = ((k / HALF) % 2) == 1;
        e_oe   = !(m_rd && b >= 46);
        e_mdio = e_oe ? fvec[63 - b] : 1'b0;
      end else begin
        e_mdc = 0; e_oe = 0; e_mdio = 0;
      end
      chk("R3", "mdc", {31'b0, mdc}, {31'b0, e_mdc});
      chk((m_rd && b >= 46) ? "R5" : "R4", "mdio_oe", {31'b0, mdio_oe}, {31'b0, e_oe});
      chk((m_rd && b >= 46) ? "R5" : "R4", "mdio", {31'b0, mdio_out}, {31'b0, e_mdio});
      chk(tag, "word", rdata,
          {m_data, m_flag, m_rd, m_wr, m_reg, 3'b000, m_phy});
      if (m_busy && m_rd && k < TOT && b >= 48) mdio_in = m_rdval[63 - b];
      else mdio_in = 1'b1;
    end
  end

  task automatic wr(input logic [31:0] w);
    @(negedge clk); we = 1'b1; wdata = w;
    @(negedge clk); we = 1'b0; wdata = '0;
  endtask

  task automatic wait_idle();
    while (m_busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  function automatic logic [31:0] mk(input logic [15:0] d, input bit rd, input bit wrb,
                                     input logic [4:0] r, input logic [4:0] p);
    return {d, 1'b0, rd, wrb, r, 3'b000, p};
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tag = "R1";
    repeat (5) @(negedge clk);
    // R2: both direction bits, then neither
    tag = "R2";
    wr(mk(16'h1234, 1, 1, 5'h03, 5'h04));
    repeat (4) @(negedge clk);
    wr(mk(16'h4321, 0, 0, 5'h05, 5'h06));
    repeat (4) @(negedge clk);
    // R4/R6: write frame
    tag = "R6";
    wr(mk(16'hA5C3, 0, 1, 5'h0A, 5'h13));
    wait_idle();
    // R7: clear only with bit 15
    tag = "R7";
    wr(32'h0000_0000);
    repeat (3) @(negedge clk);
    wr(32'h0000_8000);
    repeat (3) @(negedge clk);
    // R5: read frame, writes mid-frame ignored
    tag = "R5";
    m_rdval = 16'h5A3C;
    wr(mk(16'h0000, 1, 0, 5'h02, 5'h01));
    repeat (60) @(negedge clk);
    tag = "R8";
    wr(mk(16'hFFFF, 0, 1, 5'h1F, 5'h1F));
    wr(32'h0000_8000);
    // R8: write on the completion edge
    while (!(m_busy && k == TOT)) @(negedge clk);
    we = 1'b1; wdata = mk(16'h0F0F, 1, 0, 5'h11, 5'h12);
    @(negedge clk); we = 1'b0; wdata = '0;
    repeat (2 * TOT / 4) @(negedge clk);
    // R9: new command without clearing flag
    tag = "R9";
    m_rdval = 16'h8001;
    wr(mk(16'h0000, 1, 0, 5'h1F, 5'h00));
    wait_idle();
    tag = "R6";
    wr(mk(16'hFFFF, 0, 1, 5'h00, 5'h1F));
    wait_idle();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    checks++; fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule